// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit executes one conditional-select instruction per cycle against its own 32-entry general-purpose register file and a 4-bit condition-flag register. A 32-bit instruction word presented with `instr_valid` is checked for the conditional-select pattern. Its destination, two source and condition fields are extracted. The condition is evaluated against the flags, and the first or the second source is written back to the destination. The writeback and a registered result report appear one cycle later.

A size bit selects 64-bit operation or 32-bit operation. In 32-bit operation only the low half of each source is used and the upper half of the destination is cleared. Register index 31 reads as zero and swallows writes. The flags come from outside through a dedicated write port and are never changed by the unit. A load port fills the register file. The cycle count of every instruction is fixed and does not depend on the operands or on the outcome of the condition.

Top module: `csel_exec_unit`

## Requirements
- R1: An instruction is legal only when bit 30 = 0, bit 29 = 0, bits 28:21 = 8'b11010100, bit 11 = 0 and bit 10 = 0. For any other pattern, `res_undef` = 1, `res_wen` = 0, `res_taken` = 0 and `res_data` = 0, and the register file is not changed.
- R2: For every cycle with `instr_valid` high, `res_valid` is high in the following cycle, whatever the data or the condition. After an idle cycle, `res_valid` and all other result outputs are zero.
- R3: Fields are: Rd = bits 4:0, Rn = bits 9:5, cond = bits 15:12, Rm = bits 20:16, size = bit 31. When the condition holds, the destination receives Rn. Otherwise it receives Rm. `res_idx` always reports the Rd field.
- R4: Flag bits are N = bit 3, Z = bit 2, C = bit 1, V = bit 0. Codes 0 to 13 hold on: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 !(!Z&(N==V)). `res_taken` reports the outcome.
- R5: Codes 14 and 15 always hold.
- R6: Source index 31 reads as zero.
- R7: A legal instruction with Rd = 31 writes nothing and reports `res_wen` = 0.
- R8: With size = 0, sources are truncated to 32 bits and bits 63:32 of the result are zero. With size = 1, the full 64 bits are selected.
- R9: A flag write takes effect for instructions issued from the next cycle onward. The unit never modifies the flags.
- R10: The load port writes a register for use from the next cycle onward and cannot write index 31. If the load port and a writeback target the same register in one cycle, the writeback wins.
- R11: An active-low reset clears all registers, the flags and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| flags_we | input | 1 | Flag write enable |
| flags_wdata | input | 4 | New flags, N Z C V from bit 3 down |
| load_we | input | 1 | Register load enable |
| load_idx | input | 5 | Register load index |
| load_data | input | 64 | Register load data |
| res_valid | output | 1 | Result report valid |
| res_undef | output | 1 | Instruction was not a legal select |
| res_wen | output | 1 | Register file was written |
| res_taken | output | 1 | Condition held |
| res_idx | output | 5 | Destination index |
| res_data | output | 64 | Selected value |

## Verification
Every result output is due exactly one clock edge after the cycle in which its instruction is presented. A flag or register load becomes visible to an instruction presented one cycle after the load. The bench drives each cycle just after a rising edge and first computes the expected report from its own register and flag model. It then updates that model as the edge would, and compares every output shortly after the next rising edge, so each comparison lands in the single cycle where the result is due. Read-backs through an always-true select expose the register contents that illegal instructions, writes to index 31 and load/writeback collisions could have changed.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_COUNT = 32;
  localparam int unsigned IDX_W     = $clog2(REG_COUNT);
  localparam int unsigned ZERO_IDX  = REG_COUNT - 1;

  localparam logic [7:0] SEL_MAJOR  = 8'b1101_0100;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  typedef enum logic [2:0] {
    GRP_ZERO     = 3'd0,
    GRP_CARRY    = 3'd1,
    GRP_NEG      = 3'd2,
    GRP_OVF      = 3'd3,
    GRP_UHIGHER  = 3'd4,
    GRP_SGE      = 3'd5,
    GRP_SGT      = 3'd6,
    GRP_ALWAYS   = 3'd7
  } cond_grp_e;

  typedef struct packed {
    logic             legal;
    logic             wide;
    logic [IDX_W-1:0] src_b;
    logic [3:0]       cond;
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] dst;
  } sel_dec_t;

endpackage

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output sel_dec_t           dec
);

  logic fixed_ok;

  always_comb begin
    fixed_ok = (word[30] == 1'b0) &&
               (word[29] == 1'b0) &&
               (word[28:21] == SEL_MAJOR) &&
               (word[11] == 1'b0) &&
               (word[10] == 1'b0);
    dec.legal = fixed_ok;
    dec.wide  = word[31];
    dec.src_b = word[20:16];
    dec.cond  = word[15:12];
    dec.src_a = word[9:5];
    dec.dst   = word[4:0];
  end

endmodule

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
  import csel_pkg::*;
(
  input  logic [3:0] code,
  input  logic [3:0] nzcv,
  output logic       holds
);

  cond_grp_e grp;
  logic      base;
  logic      n_eq_v;

  always_comb begin
    grp    = cond_grp_e'(code[3:1]);
    n_eq_v = (nzcv[FLAG_N] == nzcv[FLAG_V]);
    unique case (grp)
      GRP_ZERO:    base = nzcv[FLAG_Z];
      GRP_CARRY:   base = nzcv[FLAG_C];
      GRP_NEG:     base = nzcv[FLAG_N];
      GRP_OVF:     base = nzcv[FLAG_V];
      GRP_UHIGHER: base = nzcv[FLAG_C] & ~nzcv[FLAG_Z];
      GRP_SGE:     base = n_eq_v;
      GRP_SGT:     base = ~nzcv[FLAG_Z] & n_eq_v;
      GRP_ALWAYS:  base = 1'b1;
      default:     base = 1'b1;
    endcase
    // the low code bit inverts, except in the always group
    holds = (code[0] && (grp != GRP_ALWAYS)) ? ~base : base;
  end

endmodule

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [DW-1:0]    wb_data,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [DW-1:0]    ld_data
);

  logic [DW-1:0] mem_q   [REG_COUNT];
  logic [DW-1:0] mem_nxt [REG_COUNT];
  logic          any_we;

  always_comb begin
    any_we = wb_en | ld_en;
    for (int i = 0; i < int'(REG_COUNT); i++) begin
      mem_nxt[i] = mem_q[i];
      if (i != int'(ZERO_IDX)) begin
        if (ld_en && (ld_idx == IDX_W'(i))) mem_nxt[i] = ld_data;
        // writeback is applied last so it wins a collision
        if (wb_en && (wb_idx == IDX_W'(i))) mem_nxt[i] = wb_data;
      end else begin
        mem_nxt[i] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(REG_COUNT); i++) mem_q[i] <= '0;
    end else if (any_we) begin
      for (int i = 0; i < int'(REG_COUNT); i++) mem_q[i] <= mem_nxt[i];
    end
  end

  always_comb begin
    rd_a_data = (rd_a_idx == IDX_W'(ZERO_IDX)) ? '0 : mem_q[rd_a_idx];
    rd_b_data = (rd_b_idx == IDX_W'(ZERO_IDX)) ? '0 : mem_q[rd_b_idx];
  end

endmodule

// File: rtl/csel_exec_unit.sv
module csel_exec_unit
  import csel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr_word,
  input  logic                flags_we,
  input  logic [3:0]          flags_wdata,
  input  logic                load_we,
  input  logic [IDX_W-1:0]    load_idx,
  input  logic [XLEN-1:0]     load_data,
  output logic                res_valid,
  output logic                res_undef,
  output logic                res_wen,
  output logic                res_taken,
  output logic [IDX_W-1:0]    res_idx,
  output logic [XLEN-1:0]     res_data
);

  localparam int unsigned HALF = XLEN / 2;

  sel_dec_t         dec;
  logic [XLEN-1:0]  src_a_raw, src_b_raw;
  logic [XLEN-1:0]  src_a, src_b, sel_val;
  logic             cond_ok;
  logic             wb_en;

  logic [3:0]       flags_q, flags_nxt;

  logic             valid_nxt, undef_nxt, wen_nxt, taken_nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic [XLEN-1:0]  data_nxt;
  logic             valid_q, undef_q, wen_q, taken_q;
  logic [IDX_W-1:0] idx_q;
  logic [XLEN-1:0]  data_q;
  logic             rep_en;

  csel_decode u_decode (
    .word (instr_word),
    .dec  (dec)
  );

  csel_cond_eval u_cond (
    .code  (dec.cond),
    .nzcv  (flags_q),
    .holds (cond_ok)
  );

  csel_regfile #(.DW(XLEN)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (dec.src_a),
    .rd_a_data (src_a_raw),
    .rd_b_idx  (dec.src_b),
    .rd_b_data (src_b_raw),
    .wb_en     (wb_en),
    .wb_idx    (dec.dst),
    .wb_data   (sel_val),
    .ld_en     (load_we),
    .ld_idx    (load_idx),
    .ld_data   (load_data)
  );

  // operand width: narrow mode keeps only the low half of each source
  always_comb begin
    if (dec.wide) begin
      src_a = src_a_raw;
      src_b = src_b_raw;
    end else begin
      src_a = {{(XLEN-HALF){1'b0}}, src_a_raw[HALF-1:0]};
      src_b = {{(XLEN-HALF){1'b0}}, src_b_raw[HALF-1:0]};
    end
    sel_val = cond_ok ? src_a : src_b;
    wb_en   = instr_valid && dec.legal && (dec.dst != IDX_W'(ZERO_IDX));
  end

  // flag register: only the external port changes it
  always_comb begin
    flags_nxt = flags_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_we) begin
      flags_q <= flags_nxt;
    end
  end

  // result report, next-state
  always_comb begin
    rep_en    = instr_valid | valid_q;
    valid_nxt = instr_valid;
    undef_nxt = instr_valid & ~dec.legal;
    wen_nxt   = wb_en;
    taken_nxt = instr_valid & dec.legal & cond_ok;
    idx_nxt   = instr_valid ? dec.dst : '0;
    data_nxt  = (instr_valid && dec.legal) ? sel_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      undef_q <= 1'b0;
      wen_q   <= 1'b0;
      taken_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else if (rep_en) begin
      valid_q <= valid_nxt;
      undef_q <= undef_nxt;
      wen_q   <= wen_nxt;
      taken_q <= taken_nxt;
      idx_q   <= idx_nxt;
      data_q  <= data_nxt;
    end
  end

  assign res_valid = valid_q;
  assign res_undef = undef_q;
  assign res_wen   = wen_q;
  assign res_taken = taken_q;
  assign res_idx   = idx_q;
  assign res_data  = data_q;

endmodule

// File: rtl/csel_exec_unit_chk.sv
module csel_exec_unit_chk
  import csel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr_word,
  input logic               res_valid,
  input logic               res_undef,
  input logic               res_wen,
  input logic               res_taken,
  input logic [IDX_W-1:0]   res_idx,
  input logic [XLEN-1:0]    res_data
);

  AST_REPORT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> res_valid); // R2

  AST_NO_SPURIOUS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !res_valid && !res_wen && (res_data == '0)); // R2

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_undef |-> res_valid && !res_wen && !res_taken); // R1

  AST_OPCODE_BIT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && (instr_word[30] || instr_word[10])) |=> res_undef); // R1

  AST_ZERO_DEST_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_idx == IDX_W'(ZERO_IDX))) |-> !res_wen); // R7

  AST_ALWAYS_GROUP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && (instr_word[15:13] == 3'b111) && !instr_word[30] &&
     !instr_word[29] && (instr_word[28:21] == SEL_MAJOR) &&
     !instr_word[11] && !instr_word[10]) |=> res_taken); // R5

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !instr_word[31]) |=> (res_data[XLEN-1:XLEN/2] == '0)); // R8

endmodule

bind csel_exec_unit csel_exec_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .res_valid   (res_valid),
  .res_undef   (res_undef),
  .res_wen     (res_wen),
  .res_taken   (res_taken),
  .res_idx     (res_idx),
  .res_data    (res_data)
);

// File: tb/csel_exec_unit_bench.sv
`timescale 1ns/1ps
module csel_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic        flags_we;
  logic [3:0]  flags_wdata;
  logic        load_we;
  logic [4:0]  load_idx;
  logic [63:0] load_data;
  logic        res_valid, res_undef, res_wen, res_taken;
  logic [4:0]  res_idx;
  logic [63:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] m_reg [32];
  logic [3:0]  m_flags;

  always #2 clk = ~clk;

  csel_exec_unit u_csel_exec_unit (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .flags_we(flags_we), .flags_wdata(flags_wdata),
    .load_we(load_we), .load_idx(load_idx), .load_data(load_data),
    .res_valid(res_valid), .res_undef(res_undef), .res_wen(res_wen),
    .res_taken(res_taken), .res_idx(res_idx), .res_data(res_data)
  );

  function automatic logic [31:0] enc(input bit sf, input int rm, input int c,
                                      input int rn, input int rd);
    return {sf, 2'b00, 8'hD4, 5'(rm), 4'(c), 2'b00, 5'(rn), 5'(rd)};
  endfunction

  function automatic logic [63:0] pat(input int i);
    return {32'(i) * 32'h9E37_79B9, ~(32'(i) * 32'h85EB_CA6B)};
  endfunction

  function automatic logic [63:0] mread(input int i);
    return (i == 31) ? 64'd0 : m_reg[i];
  endfunction

  function automatic bit holds(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: inputs are already driven; predict, update model, compare
  task automatic tick(input string tag);
    bit          e_valid, e_undef, e_wen, e_taken, legal;
    logic [4:0]  e_idx;
    logic [63:0] e_data, a, b;
    int          rd;
    e_valid = instr_valid; e_undef = 0; e_wen = 0; e_taken = 0;
    e_idx = '0; e_data = '0; rd = 0;
    if (instr_valid) begin
      legal = ((instr_word & 32'h7FE0_0C00) == 32'h1A80_0000);
      rd = int'(instr_word[4:0]);
      a  = mread(int'(instr_word[9:5]));
      b  = mread(int'(instr_word[20:16]));
      if (!instr_word[31]) begin
        a = {32'd0, a[31:0]};
        b = {32'd0, b[31:0]};
      end
      e_idx   = instr_word[4:0];
      e_undef = !legal;
      if (legal) begin
        e_taken = holds(instr_word[15:12], m_flags);
        e_data  = e_taken ? a : b;
        e_wen   = (rd != 31);
      end
    end
    if (flags_we) m_flags = flags_wdata;
    if (load_we && load_idx != 5'd31) m_reg[load_idx] = load_data;
    if (e_wen) m_reg[rd] = e_data;
    @(posedge clk);
    #1;
    check(res_valid === e_valid, "R2", "res_valid", 64'(res_valid), 64'(e_valid));
    check(res_undef === e_undef, "R1", "res_undef", 64'(res_undef), 64'(e_undef));
    check(res_wen === e_wen, "R7", "res_wen", 64'(res_wen), 64'(e_wen));
    check(res_taken === e_taken, "R4", "res_taken", 64'(res_taken), 64'(e_taken));
    check(res_idx === e_idx, "R3", "res_idx", 64'(res_idx), 64'(e_idx));
    check(res_data === e_data, tag, "res_data", res_data, e_data);
    instr_valid = 0; flags_we = 0; load_we = 0;
  endtask

  task automatic issue(input logic [31:0] w, input string tag);
    instr_valid = 1; instr_word = w;
    tick(tag);
  endtask

  task automatic set_flags(input logic [3:0] f);
    flags_we = 1; flags_wdata = f;
    tick("R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_flags = '0;
    rst_n = 0; instr_valid = 0; instr_word = '0;
    flags_we = 0; flags_wdata = '0;
    load_we = 0; load_idx = '0; load_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs cleared during reset
    check(res_valid === 1'b0 && res_data === 64'd0 && res_wen === 1'b0,
          "R11", "reset outputs", res_data, 64'd0);
    rst_n = 1;
    // R11: registers read zero after reset
    issue(enc(1, 6, 4'hE, 5, 9), "R11");
    issue(enc(1, 30, 4'hE, 30, 9), "R11");

    // R10: fill the register file through the load port
    for (int i = 0; i < 32; i++) begin
      load_we = 1; load_idx = 5'(i); load_data = pat(i + 1);
      tick("R10");
    end
    issue(enc(1, 2, 4'hE, 31, 8), "R6");   // R6 source 31 as Rn
    issue(enc(1, 1, 4'hE, 1, 8), "R10");   // read back a loaded value

    // R4 R5: every condition code against every flag value
    for (int f = 0; f < 16; f++) begin
      set_flags(4'(f));
      for (int c = 0; c < 16; c++)
        issue(enc(1, 30 - c, c, c + 1, 4), (c >= 14) ? "R5" : "R4");
    end

    // R3: both directions of selection with distinct sources
    set_flags(4'b0100);
    issue(enc(1, 12, 0, 11, 13), "R3");
    issue(enc(1, 12, 1, 11, 13), "R3");

    // R6: Rm = 31 selected when condition fails
    issue(enc(1, 31, 1, 11, 14), "R6");

    // R8: narrow operation, both outcomes
    issue(enc(0, 12, 0, 11, 15), "R8");
    issue(enc(0, 12, 1, 11, 15), "R8");
    issue(enc(1, 15, 4'hE, 15, 16), "R8");

    // R7: destination 31 discarded, then read it back
    issue(enc(1, 12, 4'hE, 11, 31), "R7");
    issue(enc(1, 12, 4'hE, 31, 17), "R7");

    // R1: each fixed bit disturbed, then check x3 unchanged
    begin
      int bits_to_flip[6] = '{30, 29, 28, 21, 11, 10};
      foreach (bits_to_flip[k]) begin
        issue(enc(1, 12, 4'hE, 11, 3) ^ (32'd1 << bits_to_flip[k]), "R1");
        issue(enc(1, 3, 4'hE, 3, 18), "R1");
      end
    end

    // R9: flag change applies to the very next instruction
    set_flags(4'b0000);
    flags_we = 1; flags_wdata = 4'b0100;
    instr_valid = 1; instr_word = enc(1, 12, 0, 11, 19);
    tick("R9");
    issue(enc(1, 12, 0, 11, 19), "R9");

    // R10: collision of load and writeback on one register; load to 31 ignored
    load_we = 1; load_idx = 5'd7; load_data = 64'h1111_2222_3333_4444;
    instr_valid = 1; instr_word = enc(1, 12, 4'hE, 11, 7);
    tick("R10");
    issue(enc(1, 7, 4'hE, 7, 20), "R10");
    load_we = 1; load_idx = 5'd31; load_data = 64'hFFFF_FFFF_FFFF_FFFF;
    tick("R10");
    issue(enc(1, 31, 4'hE, 31, 20), "R10");

    // R2: back-to-back dependent instructions
    issue(enc(1, 5, 4'hE, 6, 21), "R2");
    issue(enc(1, 5, 4'hE, 21, 22), "R2");

    // R2: mixed traffic with idle gaps
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(3) != 0) w = (w & ~32'h7FE0_0C00) | 32'h1A80_0000;
      instr_valid = ($urandom_range(2) != 0);
      instr_word  = w;
      flags_we    = ($urandom_range(4) == 0);
      flags_wdata = 4'($urandom);
      load_we     = ($urandom_range(5) == 0);
      load_idx    = 5'($urandom);
      load_data   = {$urandom, $urandom};
      tick("R3");
    end

    finish_run();
  end

endmodule